// File: doc/BRIEF.md
# Pin Controller with Selectable Interrupt Sense

This block is a memory-mapped general-purpose pin controller with 32-bit registers. Software picks which pins drive and which listen, reads the pin levels after a two-flop synchroniser, and drives output levels. The output level can be written as a whole word, or changed bit by bit through two aliases: one sets the bits written as 1 and the other clears them.

The low pins also feed a downstream interrupt controller, one active-high line per pin. Each line has a sense setting. With its any-edge bit clear, the pin's output-data bit picks the polarity: 0 passes the synchronised level through and 1 inverts it. The downstream controller decides whether it latches an edge or follows the level. With the any-edge bit set, the line gives a one-cycle pulse whenever the synchronised input changes, in either direction.

Top module: `gpio_polirq`

## Requirements
- R1: Registers are whole 32-bit words at byte offsets: direction 0x00, input level 0x08, output data 0x10, set alias 0x18, clear alias 0x20, any-edge mode 0x30. A write to direction or output data stores the word, and a read of those offsets returns it.
- R2: A direction bit of 1 makes the pin an output. `pad_oe` equals the direction register. `pad_out` carries the output-data bit only where the direction bit is 1, and 0 elsewhere.
- R3: Writing the set alias turns on every output-data bit written as 1 and leaves bits written as 0 unchanged.
- R4: Writing the clear alias turns off every output-data bit written as 1 and leaves bits written as 0 unchanged.
- R5: A read of offset 0x08 returns the pin inputs after a two-flop synchroniser. A level applied before clock edge k is first visible after edge k+1.
- R6: With its any-edge bit at 0 and its output-data bit at 0, an interrupt line equals the synchronised input of its pin.
- R7: With its any-edge bit at 0 and its output-data bit at 1, an interrupt line equals the inverted synchronised input.
- R8: With its any-edge bit at 1, an interrupt line is high for exactly one cycle after each rising or falling change of the synchronised input, whatever the output-data bit holds.
- R9: Only pins 0 to NIRQ-1 (default 16) have interrupt lines and any-edge bits. The any-edge register reads bits NIRQ and above as 0, and writes to those bits are dropped.
- R10: Reset (synchronous, active high) clears the direction, output-data and any-edge registers to zero.
- R11: Reads of unmapped offsets and of the two aliases return 0. Writes to unmapped offsets and to the input-level offset change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | 8 | Byte offset for both read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | NPINS | Asynchronous pin levels |
| pad_oe | output | NPINS | Per-pin output enable |
| pad_out | output | NPINS | Per-pin output level, gated by direction |
| irq_out | output | NIRQ | Active-high interrupt lines to the downstream controller |

## Verification
Register effects are due at the first clock edge after a write. Read data and `pad_out` follow combinationally, so the bench reads them at the next falling edge. A pin change made at a falling edge shows on the input register and on the level-sense lines only after two rising edges. The any-edge pulse appears after the same two edges and drops after the third. The bench therefore samples one edge early to confirm nothing has moved yet, then on the due edge, and for pulses once more on the edge after. Inputs are driven and outputs sampled at falling edges, so no check races the active edge.

// File: rtl/gpio_polirq_pkg.sv
package gpio_polirq_pkg;

    localparam int WORD_W = 32;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_DIR  = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_IN   = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_OUT  = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_SET  = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_CLR  = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_MODE = 8'h30;

    typedef enum logic [2:0] {
        RS_DIR,
        RS_IN,
        RS_OUT,
        RS_SET,
        RS_CLR,
        RS_MODE,
        RS_NONE
    } reg_sel_e;

    typedef enum logic [1:0] {
        SENSE_TRUE,
        SENSE_INV,
        SENSE_ANY
    } sense_e;

    typedef struct packed {
        logic [WORD_W-1:0] dir;
        logic [WORD_W-1:0] odata;
        logic [WORD_W-1:0] mode;
    } ctl_regs_t;

    function automatic reg_sel_e decode_offset(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        unique case (a)
            OFS_DIR:  s = RS_DIR;
            OFS_IN:   s = RS_IN;
            OFS_OUT:  s = RS_OUT;
            OFS_SET:  s = RS_SET;
            OFS_CLR:  s = RS_CLR;
            OFS_MODE: s = RS_MODE;
            default:  s = RS_NONE;
        endcase
        return s;
    endfunction

    function automatic sense_e pick_sense(input logic any_edge, input logic invert);
        if (any_edge) return SENSE_ANY;
        else if (invert) return SENSE_INV;
        else return SENSE_TRUE;
    endfunction

    function automatic logic [WORD_W-1:0] low_mask(input int n);
        logic [WORD_W-1:0] m;
        for (int i = 0; i < WORD_W; i++) m[i] = (i < n);
        return m;
    endfunction

endpackage

// File: rtl/gpio_sync_chain.sv
module gpio_sync_chain #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    always_ff @(posedge clk) begin
        stage[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            stage[s] <= stage[s-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_polirq_pkg::*;
#(
    parameter int NPINS = 32,
    parameter int NIRQ  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [NPINS-1:0]  pin_sync,
    output logic [WORD_W-1:0] rdata,
    output ctl_regs_t         regs
);
    localparam logic [WORD_W-1:0] PIN_MASK = low_mask(NPINS);
    localparam logic [WORD_W-1:0] IRQ_MASK = low_mask(NIRQ);

    reg_sel_e          sel;
    logic [WORD_W-1:0] wmask;
    logic [WORD_W-1:0] in_word;

    assign sel   = decode_offset(addr);
    assign wmask = wdata & PIN_MASK;

    always_comb begin
        in_word = '0;
        in_word[NPINS-1:0] = pin_sync;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= '0;
        end else if (wr_en) begin
            unique case (sel)
                RS_DIR:  regs.dir   <= wmask;
                RS_OUT:  regs.odata <= wmask;
                RS_SET:  regs.odata <= regs.odata | wmask;
                RS_CLR:  regs.odata <= regs.odata & ~wmask;
                RS_MODE: regs.mode  <= wdata & IRQ_MASK;
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (sel)
            RS_DIR:  rdata = regs.dir;
            RS_IN:   rdata = in_word;
            RS_OUT:  rdata = regs.odata;
            RS_MODE: rdata = regs.mode;
            default: rdata = '0;
        endcase
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (regs == '0)); // R10

    AST_SET_RAISES: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == RS_SET) |=>
        (((regs.odata & $past(wmask)) == $past(wmask)) &&
         ((regs.odata & ~$past(wmask)) == ($past(regs.odata) & ~$past(wmask))))); // R3

    AST_CLR_LOWERS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == RS_CLR) |=>
        (((regs.odata & $past(wmask)) == '0) &&
         ((regs.odata & ~$past(wmask)) == ($past(regs.odata) & ~$past(wmask))))); // R4

    AST_UNMAPPED_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (sel == RS_NONE || sel == RS_IN)) |=> $stable(regs)); // R11

    AST_MODE_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
        (regs.mode & ~IRQ_MASK) == '0); // R9
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
    import gpio_polirq_pkg::*;
#(
    parameter int NIRQ = 16
) (
    input  logic            clk,
    input  logic [NIRQ-1:0] in_sync,
    input  logic [NIRQ-1:0] invert,
    input  logic [NIRQ-1:0] any_edge,
    output logic [NIRQ-1:0] irq
);
    logic [NIRQ-1:0] prev;

    always_ff @(posedge clk) begin
        prev <= in_sync;
    end

    for (genvar i = 0; i < NIRQ; i++) begin : g_line
        logic line;
        always_comb begin
            unique case (pick_sense(any_edge[i], invert[i]))
                SENSE_TRUE: line = in_sync[i];
                SENSE_INV:  line = ~in_sync[i];
                SENSE_ANY:  line = in_sync[i] ^ prev[i];
                default:    line = 1'b0;
            endcase
        end
        assign irq[i] = line;
    end
endmodule

// File: rtl/gpio_polirq.sv
module gpio_polirq
    import gpio_polirq_pkg::*;
#(
    parameter int NPINS       = 32,
    parameter int NIRQ        = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr_en,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pad_oe,
    output logic [NPINS-1:0]  pad_out,
    output logic [NIRQ-1:0]   irq_out
);
    ctl_regs_t        regs;
    logic [NPINS-1:0] pin_sync;

    gpio_sync_chain #(
        .W      (NPINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk (clk),
        .d   (pin_in),
        .q   (pin_sync)
    );

    gpio_regfile #(
        .NPINS (NPINS),
        .NIRQ  (NIRQ)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (bus_wr_en),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .pin_sync (pin_sync),
        .rdata    (bus_rdata),
        .regs     (regs)
    );

    gpio_irq_unit #(
        .NIRQ (NIRQ)
    ) u_irq (
        .clk      (clk),
        .in_sync  (pin_sync[NIRQ-1:0]),
        .invert   (regs.odata[NIRQ-1:0]),
        .any_edge (regs.mode[NIRQ-1:0]),
        .irq      (irq_out)
    );

    assign pad_oe  = regs.dir[NPINS-1:0];
    assign pad_out = regs.odata[NPINS-1:0] & regs.dir[NPINS-1:0];

    for (genvar i = 0; i < NIRQ; i++) begin : g_chk
        AST_LEVEL_SENSE: assert property (@(posedge clk) disable iff (rst)
            !regs.mode[i] |-> (irq_out[i] == ($past(pin_in[i], 2) ^ regs.odata[i]))); // R6 R7
        AST_ANY_EDGE: assert property (@(posedge clk) disable iff (rst)
            regs.mode[i] |-> (irq_out[i] == ($past(pin_in[i], 2) ^ $past(pin_in[i], 3)))); // R8
    end

    AST_PAD_GATED: assert property (@(posedge clk) disable iff (rst)
        (pad_out & ~pad_oe) == '0); // R2
endmodule

// File: tb/tb_gpio_polirq.sv
module tb_gpio_polirq;
    localparam int NPINS = 32;
    localparam int NIRQ  = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_wr_en = 1'b0;
    logic [7:0]        bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NPINS-1:0]  pin_in = '0;
    logic [NPINS-1:0]  pad_oe;
    logic [NPINS-1:0]  pad_out;
    logic [NIRQ-1:0]   irq_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    gpio_polirq #(.NPINS(NPINS), .NIRQ(NIRQ)) dut (
        .clk       (clk),
        .rst       (rst),
        .bus_wr_en (bus_wr_en),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pad_oe    (pad_oe),
        .pad_out   (pad_out),
        .irq_out   (irq_out)
    );

    // {write offset, write data, read offset, expected read}
    localparam logic [79:0] VECS [0:9] = '{
        {8'h00, 32'hA5A5_0F0F, 8'h00, 32'hA5A5_0F0F},  // R1
        {8'h10, 32'h0000_FFFF, 8'h10, 32'h0000_FFFF},  // R1
        {8'h18, 32'hF000_0001, 8'h10, 32'hF000_FFFF},  // R3
        {8'h20, 32'h0000_00FF, 8'h10, 32'hF000_FF00},  // R4
        {8'h18, 32'h0000_0000, 8'h10, 32'hF000_FF00},  // R3
        {8'h20, 32'h0000_0000, 8'h10, 32'hF000_FF00},  // R4
        {8'h30, 32'hFFFF_1234, 8'h30, 32'h0000_1234},  // R9
        {8'h44, 32'hFFFF_FFFF, 8'h00, 32'hA5A5_0F0F},  // R11
        {8'h08, 32'hFFFF_FFFF, 8'h08, 32'h0000_0000},  // R11
        {8'h00, 32'h0000_0000, 8'h18, 32'h0000_0000}   // R11
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr_en = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        tick();
        bus_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired got=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        repeat (5) tick();
        rst = 1'b0;
        tick();

        // R10: reset state
        rd(8'h00, v); check("R10 dir after reset", v, 32'h0);
        rd(8'h10, v); check("R10 odata after reset", v, 32'h0);
        rd(8'h30, v); check("R10 mode after reset", v, 32'h0);
        check("R2 pad_oe after reset", pad_oe, 32'h0);
        check("R6 irq after reset", {16'h0, irq_out}, 32'h0);

        for (int i = 0; i < 10; i++) begin
            wr(VECS[i][79:72], VECS[i][71:40]);
            rd(VECS[i][39:32], v);
            check($sformatf("R1 table vector %0d", i), v, VECS[i][31:0]);
        end

        rd(8'h44, v); check("R11 unmapped read", v, 32'h0);
        rd(8'h20, v); check("R11 clear alias read", v, 32'h0);

        wr(8'h30, 32'h0);
        // R2: direction gating of pad_out
        wr(8'h00, 32'h0000_00F0);
        wr(8'h10, 32'h0000_0FF0);
        check("R2 pad_oe", pad_oe, 32'h0000_00F0);
        check("R2 pad_out gated", pad_out, 32'h0000_00F0);

        // R5: two-flop input sampling
        wr(8'h10, 32'h0);
        wr(8'h00, 32'h0);
        pin_in = 32'h8000_0003;
        tick();
        rd(8'h08, v); check("R5 input after one edge", v, 32'h0);
        tick();
        rd(8'h08, v); check("R5 input after two edges", v, 32'h8000_0003);

        // R6: true sense
        check("R6 irq follows input", {16'h0, irq_out}, 32'h0000_0003);
        pin_in = 32'h0;
        tick(); tick();
        check("R6 irq low again", {16'h0, irq_out}, 32'h0);

        // R7: inverted sense
        wr(8'h18, 32'h0000_0002);
        check("R7 inverted low input", {31'h0, irq_out[1]}, 32'h1);
        pin_in = 32'h0000_0002;
        tick();
        check("R7 not yet changed", {31'h0, irq_out[1]}, 32'h1);
        tick();
        check("R7 inverted high input", {31'h0, irq_out[1]}, 32'h0);

        // R8: any-edge pulses
        wr(8'h30, 32'h0000_0004);
        check("R8 idle", {31'h0, irq_out[2]}, 32'h0);
        pin_in[2] = 1'b1;
        tick();
        check("R8 rise not yet", {31'h0, irq_out[2]}, 32'h0);
        tick();
        check("R8 rise pulse", {31'h0, irq_out[2]}, 32'h1);
        tick();
        check("R8 rise pulse ends", {31'h0, irq_out[2]}, 32'h0);
        wr(8'h18, 32'h0000_0004);
        check("R8 odata ignored", {31'h0, irq_out[2]}, 32'h0);
        pin_in[2] = 1'b0;
        tick(); tick();
        check("R8 fall pulse", {31'h0, irq_out[2]}, 32'h1);
        tick();
        check("R8 fall pulse ends", {31'h0, irq_out[2]}, 32'h0);

        // R9: high pins have no line
        pin_in[2] = 1'b0;
        pin_in[1] = 1'b0;
        wr(8'h20, 32'hFFFF_FFFF);
        pin_in[20] = 1'b1;
        tick(); tick(); tick();
        check("R9 high pin no irq", {16'h0, irq_out}, 32'h0);

        // R10: reset after activity
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h10, 32'h1234_5678);
        rst = 1'b1;
        tick(); tick();
        rst = 1'b0;
        rd(8'h00, v); check("R10 dir cleared", v, 32'h0);
        rd(8'h10, v); check("R10 odata cleared", v, 32'h0);
        rd(8'h30, v); check("R10 mode cleared", v, 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule